// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the host-side controller for an analog-to-digital converter that has an active-low chip select, a combined read/convert control line, a BUSY status output and a 16-bit parallel data bus. When a start request arrives, or continuously while free-running mode is selected, the block runs one full conversion. It first lowers chip select. It then pulses the read/convert line low to begin sampling, and releases it again before the converter reports completion. It waits for BUSY to fall and then rise. It then runs a read cycle and hands the captured word to the host, together with a one-cycle valid strobe.

All converter timing rules are expressed in nanoseconds and converted to clock cycles from the clock frequency parameter. These rules are:
- the minimum length of the convert pulse;
- how long chip select must already be low before the convert edge;
- the read duration;
- the minimum spacing between convert commands, which the converter needs for acquisition;
- a BUSY timeout.

BUSY passes through a two-flop synchronizer. If BUSY never completes its low/high sequence, the block raises an error flag and returns to idle.

Top module: `adc_conv_seq`

## Requirements
- R1: Each convert command (chip select low and read/convert low together) lasts at least PULSE cycles (2 at the default 50 MHz, i.e. 40 ns).
- R2: Chip select is low for at least SETUP cycles (1 by default) with read/convert high before read/convert falls, and it stays low for the whole convert pulse.
- R3: The convert condition is removed (read/convert back high) right after the pulse, so it is never present when BUSY rises.
- R4: Successive convert commands start at least GAP cycles apart (250 by default, i.e. 5 µs).
- R5: A convert command is never started while the synchronized BUSY is low.
- R6: After BUSY returns high, a read cycle drives chip select low with read/convert high for READ cycles (2 by default). The bus is captured on the last read cycle, and `result_o` then shows that word while `result_valid_o` is high for exactly one cycle.
- R7: A `start_i` pulse is remembered until it is served. Several pulses that arrive before service are merged into a single conversion. While `free_run_i` is high, conversions repeat back to back at the spacing limit, with one valid strobe per conversion.
- R8: If BUSY has not fallen and risen again within TIMEOUT cycles (1000 by default) of the end of the convert pulse, `timeout_err_o` is set, both control lines return high, no result is produced and the block goes idle. The flag clears when the next conversion is launched.
- R9: After reset, chip select and read/convert are high, and `result_valid_o`, `timeout_err_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request for a single conversion |
| free_run_i | input | 1 | Level; repeats conversions while high |
| adc_busy_i | input | 1 | Converter BUSY, asynchronous, low while converting |
| adc_data_i | input | 16 | Converter parallel data bus |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rc_o | output | 1 | Converter read/convert line, low = convert |
| result_o | output | 16 | Last captured conversion word |
| result_valid_o | output | 1 | One-cycle strobe when result_o updates |
| timeout_err_o | output | 1 | Set by a BUSY timeout, cleared on next launch |

## Verification
A wrong sequencer state becomes visible on the two control lines within one or two cycles. For example, a convert pulse that is too short, a convert edge without chip select already low, or a pulse still active when BUSY returns would all be flagged by the converter model at the edge where they occur. A mistimed capture shows a filler word on `result_o` instead of the converter's latest value, at the very next valid strobe. A broken request latch or spacing timer shows up as a wrong number of conversions, or as a convert edge that comes too early, within a few hundred cycles. A stuck wait state shows up as a missing or late error flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONVERT,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_READ,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic rc;
    } adc_ctrl_t;

    // Round a duration in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Control line levels seen by the converter in each state.
    function automatic adc_ctrl_t ctrl_for_state(input seq_state_e s);
        adc_ctrl_t c;
        c.cs_n = 1'b1;
        c.rc   = 1'b1;
        case (s)
            ST_SETUP:   c.cs_n = 1'b0;
            ST_CONVERT: begin c.cs_n = 1'b0; c.rc = 1'b0; end
            ST_READ:    c.cs_n = 1'b0;
            default:    ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/adc_interval_timer.sv
module adc_interval_timer #(
    parameter int unsigned GAP_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic ok_o
);
    localparam int unsigned W = $clog2(GAP_CYC + 1);
    localparam logic [W-1:0] LAST = W'(GAP_CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= LAST;
        else if (restart_i)  cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign ok_o = (cnt_q == LAST);

    generate
        if (GAP_CYC > 1) begin : g_chk
            // A fresh convert command closes the window (R4).
            assert_gap_closes_R4: assert property (@(posedge clk) disable iff (rst)
                restart_i |=> !ok_o);
        end
    endgenerate
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned PULSE_CYC = 2,
    parameter int unsigned READ_CYC  = 2,
    parameter int unsigned TMO_CYC   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              free_run_i,
    input  logic              busy_s_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              gap_ok_i,
    output logic              gap_restart_o,
    output logic              cs_n_o,
    output logic              rc_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int unsigned CW = $clog2(max3(SETUP_CYC, PULSE_CYC, READ_CYC) + 1);
    localparam int unsigned TW = $clog2(TMO_CYC + 1);

    seq_state_e        state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [TW-1:0]     tmo_q;
    logic              pend_q, err_q, valid_q;
    logic [DATA_W-1:0] res_q;
    adc_ctrl_t         ctrl_q;
    logic              launch, tmo_hit, tmo_fire, capture, in_wait;

    always_comb begin
        launch  = (state_q == ST_IDLE) && (pend_q || free_run_i) && gap_ok_i && busy_s_i;
        tmo_hit = (tmo_q == TW'(TMO_CYC - 1));
        in_wait = (state_q == ST_WAIT_LO) || (state_q == ST_WAIT_HI);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch) state_d = ST_SETUP;
            ST_SETUP:   if (cnt_q == CW'(SETUP_CYC - 1)) state_d = ST_CONVERT;
            ST_CONVERT: if (cnt_q == CW'(PULSE_CYC - 1)) state_d = ST_WAIT_LO;
            ST_WAIT_LO: if (!busy_s_i) state_d = ST_WAIT_HI;
                        else if (tmo_hit) state_d = ST_IDLE;
            ST_WAIT_HI: if (busy_s_i) state_d = ST_READ;
                        else if (tmo_hit) state_d = ST_IDLE;
            ST_READ:    if (cnt_q == CW'(READ_CYC - 1)) state_d = ST_GAP;
            ST_GAP:     if (gap_ok_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        tmo_fire      = in_wait && (state_d == ST_IDLE);
        capture       = (state_q == ST_READ) && (state_d == ST_GAP);
        gap_restart_o = (state_d == ST_CONVERT) && (state_q != ST_CONVERT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmo_q   <= '0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
            res_q   <= '0;
            ctrl_q  <= ctrl_for_state(ST_IDLE);
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == ST_CONVERT) tmo_q <= '0;
            else if (in_wait)          tmo_q <= tmo_q + 1'b1;
            pend_q  <= launch ? 1'b0 : (pend_q | start_i);
            if (launch)        err_q <= 1'b0;
            else if (tmo_fire) err_q <= 1'b1;
            valid_q <= capture;
            if (capture) res_q <= data_i;
            ctrl_q  <= ctrl_for_state(state_d);
        end
    end

    assign cs_n_o   = ctrl_q.cs_n;
    assign rc_o     = ctrl_q.rc;
    assign result_o = res_q;
    assign valid_o  = valid_q;
    assign err_o    = err_q;

    // A stalled BUSY wait ends in idle with the error flag and lines high (R8).
    assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (((state_q == ST_WAIT_LO) && busy_s_i) || ((state_q == ST_WAIT_HI) && !busy_s_i)) && tmo_hit
        |=> (state_q == ST_IDLE) && err_o && cs_n_o && rc_o);

    // A result strobe only follows a read cycle (R6).
    assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(state_q) == ST_READ) && !$past(valid_o));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 50,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned SYNC_STG   = 2,
    parameter int unsigned PULSE_NS   = 40,
    parameter int unsigned SETUP_NS   = 10,
    parameter int unsigned READ_NS    = 40,
    parameter int unsigned GAP_NS     = 5000,
    parameter int unsigned TIMEOUT_NS = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              free_run_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_cs_n_o,
    output logic              adc_rc_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              timeout_err_o
);
    localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_MHZ);
    localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_MHZ);
    localparam int unsigned READ_CYC  = ns_to_cycles(READ_NS, CLK_MHZ);
    localparam int unsigned GAP_CYC   = ns_to_cycles(GAP_NS, CLK_MHZ);
    localparam int unsigned TMO_CYC   = ns_to_cycles(TIMEOUT_NS, CLK_MHZ);

    logic busy_s, gap_ok, gap_restart;

    adc_busy_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .async_i(adc_busy_i), .sync_o(busy_s)
    );

    adc_interval_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst(rst), .restart_i(gap_restart), .ok_o(gap_ok)
    );

    adc_seq_fsm #(
        .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .READ_CYC(READ_CYC), .TMO_CYC(TMO_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i), .free_run_i(free_run_i),
        .busy_s_i(busy_s), .data_i(adc_data_i), .gap_ok_i(gap_ok),
        .gap_restart_o(gap_restart), .cs_n_o(adc_cs_n_o), .rc_o(adc_rc_o),
        .result_o(result_o), .valid_o(result_valid_o), .err_o(timeout_err_o)
    );

    // Port-level protocol checkers.
    localparam int unsigned LW = $clog2(PULSE_CYC + 1);
    localparam int unsigned GW = $clog2(GAP_CYC + 1);

    logic          conv_lo, conv_lo_d, conv_rise, seen_q;
    logic [LW-1:0] lo_run_q;
    logic [GW-1:0] since_q;

    assign conv_lo   = !adc_cs_n_o && !adc_rc_o;
    assign conv_rise = conv_lo && !conv_lo_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_lo_d <= 1'b0;
            lo_run_q  <= '0;
            since_q   <= '0;
            seen_q    <= 1'b0;
        end else begin
            conv_lo_d <= conv_lo;
            if (!conv_lo)                      lo_run_q <= '0;
            else if (lo_run_q != LW'(PULSE_CYC)) lo_run_q <= lo_run_q + 1'b1;
            if (conv_rise) begin
                since_q <= GW'(1);
                seen_q  <= 1'b1;
            end else if (since_q != GW'(GAP_CYC)) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    assert_pulse_width_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_lo) |-> (lo_run_q == LW'(PULSE_CYC)));

    assert_cs_setup_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_rc_o) |-> $past(!adc_cs_n_o) && !adc_cs_n_o);

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_s) |-> !conv_lo);

    assert_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        conv_rise |-> (!seen_q || (since_q == GW'(GAP_CYC))));

    assert_idle_converter_R5: assert property (@(posedge clk) disable iff (rst)
        conv_rise |-> busy_s);
endmodule

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
    localparam int PULSE = 2;    // 40 ns at 20 ns period
    localparam int SETUP = 1;
    localparam int GAP   = 250;  // 5 us
    localparam int TMO   = 1000; // 20 us

    logic        clk = 1'b0;
    logic        rst, start, free_run, busy;
    logic [15:0] bus, result;
    logic        cs_n, rc, valid, err;
    logic [15:0] data_reg;

    int checks = 0, errors = 0;
    int cyc = 0, conv_count = 0, valid_count = 0;
    int last_start = 0, have_start = 0, lo_run = 0;
    int phase = 0, tcount = 0;
    bit stuck = 0, conv_prev = 0, prev_cs_n = 1, prev_rc = 1, valid_prev = 0;
    logic [15:0] exp_last = 16'h0;

    always #10 clk = ~clk;

    // Bus shows the data word only during a read, a filler value otherwise.
    assign bus = (!cs_n && rc) ? data_reg : 16'hDEAD;

    adc_conv_seq u0 (
        .clk(clk), .rst(rst), .start_i(start), .free_run_i(free_run),
        .adc_busy_i(busy), .adc_data_i(bus), .adc_cs_n_o(cs_n), .adc_rc_o(rc),
        .result_o(result), .result_valid_o(valid), .timeout_err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int conv_time();
        return 20 + int'($urandom % 200);
    endfunction

    // Converter model and protocol monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        bit conv_lo;
        cyc++;
        if (rst) begin
            busy = 1'b1; phase = 0; conv_prev = 0; lo_run = 0; valid_prev = 0;
        end else begin
            conv_lo = !cs_n && !rc;
            if (conv_lo && !conv_prev) begin
                conv_count++;
                chk(busy == 1'b1, "R5 convert while busy low", busy, 1);
                chk(prev_cs_n == 0 && prev_rc == 1, "R2 chip select setup", {prev_cs_n, prev_rc}, 2'b01);
                if (have_start != 0)
                    chk(cyc - last_start >= GAP, "R4 convert spacing", cyc - last_start, GAP);
                last_start = cyc; have_start = 1;
                if (!stuck) begin phase = 1; tcount = 2; end
            end
            if (!conv_lo && conv_prev)
                chk(lo_run >= PULSE, "R1 pulse width", lo_run, PULSE);
            lo_run = conv_lo ? lo_run + 1 : 0;
            case (phase)
                1: begin
                    tcount--;
                    if (tcount == 0) begin busy = 1'b0; tcount = conv_time(); phase = 2; end
                end
                2: begin
                    tcount--;
                    if (tcount == 0) begin
                        chk(!conv_lo, "R3 released before busy rises", conv_lo, 0);
                        busy = 1'b1;
                        data_reg = 16'($urandom);
                        exp_last = data_reg;
                        phase = 0;
                    end
                end
                default: ;
            endcase
            if (valid) begin
                valid_count++;
                chk(result == exp_last, "R6 captured word", result, exp_last);
                chk(!valid_prev, "R6 single-cycle strobe", valid_prev, 0);
            end
            valid_prev = valid;
            conv_prev = conv_lo;
            prev_cs_n = cs_n;
            prev_rc   = rc;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        finish_run();
    end

    initial begin
        int c0, v0, dummy;
        dummy = int'($urandom(32'd1234));
        data_reg = 16'h0;
        busy = 1'b1;
        rst = 1'b1; start = 1'b0; free_run = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cs_n == 1'b1, "R9 cs_n after reset", cs_n, 1);
        chk(rc == 1'b1, "R9 rc after reset", rc, 1);
        chk(valid == 1'b0, "R9 valid after reset", valid, 0);
        chk(err == 1'b0, "R9 error after reset", err, 0);
        chk(result == 16'h0, "R9 result after reset", result, 0);

        // Random single conversions with random idle times
        for (int i = 0; i < 20; i++) begin
            c0 = conv_count; v0 = valid_count;
            pulse_start();
            repeat (520 + int'($urandom % 200)) @(negedge clk);
            chk(conv_count - c0 == 1, "R7 one conversion per request", conv_count - c0, 1);
            chk(valid_count - v0 == 1, "R6 one strobe per conversion", valid_count - v0, 1);
            chk(err == 1'b0, "R8 no error on normal run", err, 0);
        end

        // Request right after a result: spacing must still be honoured (R4 monitor)
        pulse_start();
        @(negedge clk);
        while (!valid) @(negedge clk);
        c0 = conv_count;
        pulse_start();
        repeat (700) @(negedge clk);
        chk(conv_count - c0 == 1, "R4 back-to-back request served", conv_count - c0, 1);

        // Several requests before service merge into one extra conversion
        c0 = conv_count; v0 = valid_count;
        pulse_start();
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        repeat (1400) @(negedge clk);
        chk(conv_count - c0 == 2, "R7 merged requests", conv_count - c0, 2);
        chk(valid_count - v0 == 2, "R7 merged request strobes", valid_count - v0, 2);

        // BUSY never falls: timeout
        stuck = 1'b1;
        c0 = conv_count; v0 = valid_count;
        pulse_start();
        repeat (TMO + 100) @(negedge clk);
        chk(conv_count - c0 == 1, "R8 convert issued before timeout", conv_count - c0, 1);
        chk(err == 1'b1, "R8 error flag set", err, 1);
        chk(cs_n == 1'b1 && rc == 1'b1, "R8 lines idle after timeout", {cs_n, rc}, 2'b11);
        chk(valid_count == v0, "R8 no result after timeout", valid_count - v0, 0);
        stuck = 1'b0;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(err == 1'b0, "R8 error cleared on next launch", err, 1'b0);
        repeat (600) @(negedge clk);
        chk(valid_count - v0 == 1, "R8 recovery conversion", valid_count - v0, 1);

        // Free-running mode
        c0 = conv_count; v0 = valid_count;
        @(negedge clk) free_run = 1'b1;
        repeat (4000) @(negedge clk);
        free_run = 1'b0;
        repeat (700) @(negedge clk);
        chk((conv_count - c0) >= 12 && (conv_count - c0) <= 17, "R7 free-run conversion count",
            conv_count - c0, 15);
        chk(valid_count - v0 == conv_count - c0, "R7 free-run strobes", valid_count - v0, conv_count - c0);
        chk(cs_n == 1'b1 && rc == 1'b1, "R7 idle after free-run", {cs_n, rc}, 2'b11);

        finish_run();
    end
endmodule